// File: doc/BRIEF.md
# Integer Decode and Execute Stage

This block takes one 32-bit instruction word together with the two operand values already read from the register file. In a single pass it decodes the instruction, selects the operands, computes the integer result and picks the destination index. All of it is captured in one stage register. The outputs of that register act as the write port of a 32-entry register file and carry the decoded control bundle for later stages.

Decoding is driven by a table indexed by the 6-bit major opcode. Each entry holds a set of control flags, an ALU operation and an immediate-extension choice. One flag marks the opcode as implemented. Any opcode without it, and any unimplemented function code under the register-register opcode, raises an unsupported indication. Such an instruction produces an all-zero bundle, so it has no architectural effect.

The two conditional moves compute their result as usual. Their register write is withdrawn during execute when the tested operand fails the condition.

Top module: `dx_unit`

## Requirements
- R1: While `rst_n` is low, the stage register holds a no-operation: `instr_o`, `ctrl_o`, `aluop_o`, `result_o` and `dest_o` are zero, and `wr_en_o` and `unsup_o` are low.
- R2: Every output reflects the inputs captured at the most recent rising clock edge. A change of the inputs between edges leaves the outputs unchanged.
- R3: Under opcode 0, `aluop_o` equals the function field. The following function codes are implemented: 0, 2, 3, 4, 6, 7, 10, 11, 32 to 39, 42 and 43. Add and subtract with codes 32 to 35 wrap modulo 2^32. Codes 42 and 43 give 1 or 0 as a signed or unsigned less-than.
- R4: Function codes 0, 2 and 3 shift the rt value by bits 10:6 of the instruction. Codes 4, 6 and 7 shift it by the low five bits of the rs value. Codes 3 and 7 replicate the sign bit.
- R5: Opcodes 8 to 14 map to ALU codes 32, 33, 42, 43, 36, 37 and 38 in that order. The second operand is the immediate, bits 15:0. The destination is the rt field, bits 20:16.
- R6: The immediate is sign-extended for opcodes 8 to 11 and zero-extended for opcodes 12 to 14.
- R7: Function code 10 withdraws the register write when the rt value is non-zero. Function code 11 withdraws it when the rt value is zero. In both cases the result is the rs value and `ctrl_o` bit 5 shows the withdrawal.
- R8: Opcodes 1 to 7 and 15 to 63 set `unsup_o`. They drive `ctrl_o`, `aluop_o`, `result_o`, `dest_o` and `wr_en_o` to zero.
- R9: Under opcode 0, every function code not listed in R3 behaves as in R8.
- R10: A write aimed at register index 0 is discarded. `wr_en_o` stays low even though `ctrl_o` bit 5 is set.
- R11: The `ctrl_o` bits are: 0 implemented, 1 load data to register, 2 memory write, 3 immediate operand, 4 destination from rd (bits 15:11), 5 register write, 6 branch. A register-register instruction gives 0x31 and an immediate instruction gives 0x29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word to decode |
| rs_val_i | input | DATA_W | Register value selected by bits 25:21 |
| rt_val_i | input | DATA_W | Register value selected by bits 20:16 |
| instr_o | output | 32 | Registered instruction word |
| ctrl_o | output | 7 | Registered control flags (R11) |
| aluop_o | output | 6 | Registered ALU operation code |
| result_o | output | DATA_W | Registered result, register-file write data |
| dest_o | output | 5 | Registered destination index, write address |
| wr_en_o | output | 1 | Register-file write enable |
| unsup_o | output | 1 | Unsupported-instruction indication |

## Verification
The stage register is the only state in the block. A wrong table entry, a wrong extension choice or a wrong operand choice therefore shows at the ports exactly one edge after the offending instruction is presented, and the next instruction overwrites it. The ALU and decode are exercised with operands chosen so that sign or zero extension, a wrong shift source, or signed versus unsigned comparison give distinct results. A fault in the cancel or index-0 gating would be visible only on `wr_en_o` while `result_o` and `dest_o` still look correct, so both conditions of each conditional move and a zero-index immediate write are checked against the enable alone.

// File: rtl/dx_pkg.sv
package dx_pkg;

   localparam int INSN_W = 32;
   localparam int OPC_W  = 6;
   localparam int FN_W   = 6;
   localparam int IDX_W  = 5;
   localparam int SH_W   = 5;
   localparam int IMM_W  = 16;

   // control flag positions
   localparam int F_SUP   = 0;
   localparam int F_LDREG = 1;
   localparam int F_MEMWR = 2;
   localparam int F_IMM   = 3;
   localparam int F_RD    = 4;
   localparam int F_RW    = 5;
   localparam int F_BR    = 6;
   localparam int NFLAG   = 7;

   typedef enum logic [FN_W-1:0] {
      OP_SLL  = 6'd0,  OP_SRL  = 6'd2,  OP_SRA  = 6'd3,
      OP_SLLV = 6'd4,  OP_SRLV = 6'd6,  OP_SRAV = 6'd7,
      OP_MOVZ = 6'd10, OP_MOVN = 6'd11,
      OP_ADD  = 6'd32, OP_ADDU = 6'd33, OP_SUB  = 6'd34, OP_SUBU = 6'd35,
      OP_AND  = 6'd36, OP_OR   = 6'd37, OP_XOR  = 6'd38, OP_NOR  = 6'd39,
      OP_SLT  = 6'd42, OP_SLTU = 6'd43
   } alu_op_e;

   typedef enum logic [1:0] {
      FC_NONE = 2'd0,
      FC_BASE = 2'd1,
      FC_CMOV = 2'd2,
      FC_VSH  = 2'd3
   } fn_class_e;

   typedef struct packed {
      logic [NFLAG-1:0] flags;
      alu_op_e          op;
      logic             sext;
   } dec_ent_t;

   localparam logic [NFLAG-1:0] FL_REG = NFLAG'((1 << F_SUP) | (1 << F_RD)  | (1 << F_RW));
   localparam logic [NFLAG-1:0] FL_IMM = NFLAG'((1 << F_SUP) | (1 << F_IMM) | (1 << F_RW));

   // opcode lookup: anything not listed is an all-zero, unimplemented entry
   function automatic dec_ent_t opc_entry(input logic [OPC_W-1:0] opc);
      dec_ent_t e;
      e = '{flags: '0, op: OP_SLL, sext: 1'b0};
      case (opc)
         6'd0:  e = '{flags: FL_REG, op: OP_SLL,  sext: 1'b0};
         6'd8:  e = '{flags: FL_IMM, op: OP_ADD,  sext: 1'b1};
         6'd9:  e = '{flags: FL_IMM, op: OP_ADDU, sext: 1'b1};
         6'd10: e = '{flags: FL_IMM, op: OP_SLT,  sext: 1'b1};
         6'd11: e = '{flags: FL_IMM, op: OP_SLTU, sext: 1'b1};
         6'd12: e = '{flags: FL_IMM, op: OP_AND,  sext: 1'b0};
         6'd13: e = '{flags: FL_IMM, op: OP_OR,   sext: 1'b0};
         6'd14: e = '{flags: FL_IMM, op: OP_XOR,  sext: 1'b0};
         default: ;
      endcase
      return e;
   endfunction

   function automatic fn_class_e fn_class(input logic [FN_W-1:0] fn);
      case (fn)
         6'd0, 6'd2, 6'd3,
         6'd32, 6'd33, 6'd34, 6'd35,
         6'd36, 6'd37, 6'd38, 6'd39,
         6'd42, 6'd43:          return FC_BASE;
         6'd10, 6'd11:          return FC_CMOV;
         6'd4, 6'd6, 6'd7:      return FC_VSH;
         default:               return FC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/dx_decode.sv
module dx_decode
   import dx_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit EN_CMOV      = 1'b1,
   parameter bit EN_VAR_SHIFT = 1'b1
) (
   input  logic [OPC_W-1:0]  opc,
   input  logic [FN_W-1:0]   fn,
   input  logic [IDX_W-1:0]  rt_idx,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [IMM_W-1:0]  imm,
   output logic [NFLAG-1:0]  flags,
   output alu_op_e           op,
   output logic [DATA_W-1:0] imm_ext,
   output logic [IDX_W-1:0]  dest,
   output logic              unsup
);

   localparam int EXT_W = DATA_W - IMM_W;

   dec_ent_t  ent;
   fn_class_e cls;
   logic      cmov_ok;
   logic      vsh_ok;
   logic      fn_ok;

   generate
      if (EN_CMOV) begin : g_cmov_on
         assign cmov_ok = 1'b1;
      end else begin : g_cmov_off
         assign cmov_ok = 1'b0;
      end
      if (EN_VAR_SHIFT) begin : g_vsh_on
         assign vsh_ok = 1'b1;
      end else begin : g_vsh_off
         assign vsh_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      ent   = opc_entry(opc);
      cls   = fn_class(fn);
      fn_ok = (cls == FC_BASE) ||
              ((cls == FC_CMOV) && cmov_ok) ||
              ((cls == FC_VSH)  && vsh_ok);
      unsup = !ent.flags[F_SUP] || ((opc == '0) && !fn_ok);

      flags   = unsup ? '0 : ent.flags;
      op      = unsup ? OP_SLL : ((opc == '0) ? alu_op_e'(fn) : ent.op);
      imm_ext = ent.sext ? {{EXT_W{imm[IMM_W-1]}}, imm} : {{EXT_W{1'b0}}, imm};
      if (unsup)
         dest = '0;
      else if (ent.flags[F_RD])
         dest = rd_idx;
      else
         dest = rt_idx;
   end

endmodule

// File: rtl/dx_alu.sv
module dx_alu
   import dx_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit EN_VAR_SHIFT = 1'b1
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [SH_W-1:0]   shamt,
   output logic [DATA_W-1:0] y
);

   logic [SH_W-1:0] vsh;

   generate
      if (EN_VAR_SHIFT) begin : g_vsh
         assign vsh = a[SH_W-1:0];
      end else begin : g_no_vsh
         assign vsh = '0;
      end
   endgenerate

   always_comb begin
      case (op)
         OP_SLL:  y = b << shamt;
         OP_SRL:  y = b >> shamt;
         OP_SRA:  y = DATA_W'($signed(b) >>> shamt);
         OP_SLLV: y = b << vsh;
         OP_SRLV: y = b >> vsh;
         OP_SRAV: y = DATA_W'($signed(b) >>> vsh);
         OP_MOVZ,
         OP_MOVN: y = a;
         OP_ADD,
         OP_ADDU: y = a + b;
         OP_SUB,
         OP_SUBU: y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOR:  y = ~(a | b);
         OP_SLT:  y = DATA_W'($signed(a) < $signed(b));
         OP_SLTU: y = DATA_W'(a < b);
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/dx_unit.sv
module dx_unit
   import dx_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit EN_CMOV      = 1'b1,
   parameter bit EN_VAR_SHIFT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [INSN_W-1:0]    instr_i,
   input  logic [DATA_W-1:0]    rs_val_i,
   input  logic [DATA_W-1:0]    rt_val_i,
   output logic [INSN_W-1:0]    instr_o,
   output logic [NFLAG-1:0]     ctrl_o,
   output logic [FN_W-1:0]      aluop_o,
   output logic [DATA_W-1:0]    result_o,
   output logic [IDX_W-1:0]     dest_o,
   output logic                 wr_en_o,
   output logic                 unsup_o
);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("dx_unit: DATA_W must be 32");
      end
   endgenerate

   typedef struct packed {
      logic [INSN_W-1:0] instr;
      logic [NFLAG-1:0]  ctrl;
      logic [FN_W-1:0]   op;
      logic [DATA_W-1:0] result;
      logic [IDX_W-1:0]  dest;
      logic              wr;
      logic              unsup;
   } stage_t;

   logic [NFLAG-1:0]  dec_flags;
   alu_op_e           dec_op;
   logic [DATA_W-1:0] imm_ext;
   logic [IDX_W-1:0]  dec_dest;
   logic              dec_unsup;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] alu_y;
   logic              cancel;
   stage_t            nxt;
   stage_t            stg;

   dx_decode #(
      .DATA_W       (DATA_W),
      .EN_CMOV      (EN_CMOV),
      .EN_VAR_SHIFT (EN_VAR_SHIFT)
   ) u_dec (
      .opc     (instr_i[31:26]),
      .fn      (instr_i[5:0]),
      .rt_idx  (instr_i[20:16]),
      .rd_idx  (instr_i[15:11]),
      .imm     (instr_i[15:0]),
      .flags   (dec_flags),
      .op      (dec_op),
      .imm_ext (imm_ext),
      .dest    (dec_dest),
      .unsup   (dec_unsup)
   );

   assign opnd_b = dec_flags[F_IMM] ? imm_ext : rt_val_i;

   dx_alu #(
      .DATA_W       (DATA_W),
      .EN_VAR_SHIFT (EN_VAR_SHIFT)
   ) u_alu (
      .op    (dec_op),
      .a     (rs_val_i),
      .b     (opnd_b),
      .shamt (instr_i[10:6]),
      .y     (alu_y)
   );

   // conditional moves withdraw their write when the test on rt fails
   always_comb begin
      cancel = ((dec_op == OP_MOVZ) && (rt_val_i != '0)) ||
               ((dec_op == OP_MOVN) && (rt_val_i == '0));
      nxt.instr        = instr_i;
      nxt.ctrl         = dec_flags;
      nxt.ctrl[F_RW]   = dec_flags[F_RW] & ~cancel;
      nxt.op           = dec_op;
      nxt.result       = dec_unsup ? '0 : alu_y;
      nxt.dest         = dec_dest;
      nxt.wr           = nxt.ctrl[F_RW] && (dec_dest != '0);
      nxt.unsup        = dec_unsup;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stg <= '0;
      else
         stg <= nxt;
   end

   assign instr_o  = stg.instr;
   assign ctrl_o   = stg.ctrl;
   assign aluop_o  = stg.op;
   assign result_o = stg.result;
   assign dest_o   = stg.dest;
   assign wr_en_o  = stg.wr;
   assign unsup_o  = stg.unsup;

endmodule

// File: rtl/dx_unit_chk.sv
module dx_unit_chk
   import dx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [INSN_W-1:0]    instr_i,
   input logic [DATA_W-1:0]    rt_val_i,
   input logic [INSN_W-1:0]    instr_o,
   input logic [NFLAG-1:0]     ctrl_o,
   input logic [DATA_W-1:0]    result_o,
   input logic [IDX_W-1:0]     dest_o,
   input logic                 wr_en_o,
   input logic                 unsup_o
);

   logic [OPC_W-1:0] opc;
   logic             opc_known;
   logic             is_imm;

   assign opc       = instr_i[31:26];
   assign is_imm    = (opc >= 6'd8) && (opc <= 6'd14);
   assign opc_known = (opc == 6'd0) || is_imm;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (instr_o == '0 && ctrl_o == '0 && result_o == '0 &&
                  dest_o == '0 && !wr_en_o && !unsup_o));

   assert_imm_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_imm |=> (dest_o == $past(instr_i[20:16]) && ctrl_o[F_IMM] && !ctrl_o[F_RD]));

   assert_cmov_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == 6'd0 && ((instr_i[5:0] == 6'd10 && rt_val_i != '0) ||
                       (instr_i[5:0] == 6'd11 && rt_val_i == '0)))
      |=> (!wr_en_o && !ctrl_o[F_RW]));

   assert_unsup_opc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !opc_known |=> (unsup_o && !wr_en_o && ctrl_o == '0));

   assert_unsup_funct_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == 6'd0 && fn_class(instr_i[5:0]) == FC_NONE) |=> (unsup_o && !wr_en_o));

   assert_zero_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_imm && instr_i[20:16] == '0) |=> (!wr_en_o && ctrl_o[F_RW]));

endmodule

bind dx_unit dx_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .instr_i  (instr_i),
   .rt_val_i (rt_val_i),
   .instr_o  (instr_o),
   .ctrl_o   (ctrl_o),
   .result_o (result_o),
   .dest_o   (dest_o),
   .wr_en_o  (wr_en_o),
   .unsup_o  (unsup_o)
);

// File: tb/dx_unit_test.sv
module dx_unit_test;

   localparam int CLK_P = 10;

   function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                         input logic [4:0] rd, input logic [4:0] sh,
                                         input logic [5:0] fn);
      return {6'd0, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] opc, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
      return {opc, rs, rt, imm};
   endfunction

   typedef struct packed {
      logic [31:0] instr;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [31:0] res;
      logic [4:0]  dest;
      logic [6:0]  ctrl;
      logic [5:0]  op;
      logic        we;
      logic        unsup;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VEC [NV] = '{
      // R3: register-register arithmetic and logic
      '{enc_r(1,2,3,0,33),  32'd5,        32'd7,        32'd12,       5'd3,  7'h31, 6'd33, 1'b1, 1'b0, 8'd3},
      '{enc_r(1,2,4,0,34),  32'd5,        32'd7,        32'hFFFFFFFE, 5'd4,  7'h31, 6'd34, 1'b1, 1'b0, 8'd3},
      '{enc_r(1,2,8,0,32),  32'h7FFFFFFF, 32'd1,        32'h80000000, 5'd8,  7'h31, 6'd32, 1'b1, 1'b0, 8'd3},
      '{enc_r(1,2,9,0,39),  32'hF0F0F0F0, 32'h0F0F0000, 32'h00000F0F, 5'd9,  7'h31, 6'd39, 1'b1, 1'b0, 8'd3},
      '{enc_r(1,2,10,0,42), 32'hFFFFFFFF, 32'd1,        32'd1,        5'd10, 7'h31, 6'd42, 1'b1, 1'b0, 8'd3},
      '{enc_r(1,2,11,0,43), 32'hFFFFFFFF, 32'd1,        32'd0,        5'd11, 7'h31, 6'd43, 1'b1, 1'b0, 8'd3},
      // R4: shifts
      '{enc_r(1,2,5,4,0),   32'h0000DEAD, 32'd1,        32'h00000010, 5'd5,  7'h31, 6'd0,  1'b1, 1'b0, 8'd4},
      '{enc_r(1,2,6,4,3),   32'd0,        32'h80000000, 32'hF8000000, 5'd6,  7'h31, 6'd3,  1'b1, 1'b0, 8'd4},
      '{enc_r(1,2,7,0,6),   32'h00000028, 32'h80000000, 32'h00800000, 5'd7,  7'h31, 6'd6,  1'b1, 1'b0, 8'd4},
      '{enc_r(1,2,12,9,7),  32'd4,        32'hF0000000, 32'hFF000000, 5'd12, 7'h31, 6'd7,  1'b1, 1'b0, 8'd4},
      // R6: immediate extension
      '{enc_i(8,1,13,16'hFFFF),  32'd10,        32'h55, 32'd9,        5'd13, 7'h29, 6'd32, 1'b1, 1'b0, 8'd6},
      '{enc_i(10,1,14,16'hFFFF), 32'hFFFFFFFE,  32'h55, 32'd1,        5'd14, 7'h29, 6'd42, 1'b1, 1'b0, 8'd6},
      '{enc_i(11,1,15,16'hFFFF), 32'd5,         32'h55, 32'd1,        5'd15, 7'h29, 6'd43, 1'b1, 1'b0, 8'd6},
      '{enc_i(12,1,16,16'hFFFF), 32'h12345678,  32'h55, 32'h00005678, 5'd16, 7'h29, 6'd36, 1'b1, 1'b0, 8'd6},
      '{enc_i(14,1,17,16'h8000), 32'd0,         32'h55, 32'h00008000, 5'd17, 7'h29, 6'd38, 1'b1, 1'b0, 8'd6},
      // R5: immediate operand and rt destination
      '{enc_i(13,1,18,16'h00F0), 32'h0000000F,  32'h55, 32'h000000FF, 5'd18, 7'h29, 6'd37, 1'b1, 1'b0, 8'd5},
      '{enc_i(9,1,19,16'h7FFF),  32'd1,         32'h55, 32'h00008000, 5'd19, 7'h29, 6'd33, 1'b1, 1'b0, 8'd5},
      // R10: write to index 0 discarded
      '{enc_i(13,1,0,16'h0002),  32'd1,         32'h55, 32'd3,        5'd0,  7'h29, 6'd37, 1'b0, 1'b0, 8'd10},
      // R7: conditional moves
      '{enc_r(1,2,20,0,10), 32'hAB, 32'd0, 32'hAB, 5'd20, 7'h31, 6'd10, 1'b1, 1'b0, 8'd7},
      '{enc_r(1,2,20,0,10), 32'hAB, 32'd1, 32'hAB, 5'd20, 7'h11, 6'd10, 1'b0, 1'b0, 8'd7},
      '{enc_r(1,2,21,0,11), 32'hCD, 32'd5, 32'hCD, 5'd21, 7'h31, 6'd11, 1'b1, 1'b0, 8'd7},
      '{enc_r(1,2,21,0,11), 32'hCD, 32'd0, 32'hCD, 5'd21, 7'h11, 6'd11, 1'b0, 1'b0, 8'd7},
      // R8: unsupported opcodes
      '{32'h08123456,             32'd3, 32'd4, 32'd0, 5'd0, 7'h00, 6'd0, 1'b0, 1'b1, 8'd8},
      '{enc_i(15,0,5,16'h1234),   32'd3, 32'd4, 32'd0, 5'd0, 7'h00, 6'd0, 1'b0, 1'b1, 8'd8},
      '{enc_i(35,1,2,16'h0004),   32'd3, 32'd4, 32'd0, 5'd0, 7'h00, 6'd0, 1'b0, 1'b1, 8'd8},
      '{32'hFC0018A5,             32'd3, 32'd4, 32'd0, 5'd0, 7'h00, 6'd0, 1'b0, 1'b1, 8'd8},
      // R9: unsupported function codes under opcode 0
      '{enc_r(1,2,3,0,8),   32'd3, 32'd4, 32'd0, 5'd0, 7'h00, 6'd0, 1'b0, 1'b1, 8'd9},
      '{enc_r(1,2,3,0,1),   32'd3, 32'd4, 32'd0, 5'd0, 7'h00, 6'd0, 1'b0, 1'b1, 8'd9},
      '{enc_r(1,2,3,0,24),  32'd3, 32'd4, 32'd0, 5'd0, 7'h00, 6'd0, 1'b0, 1'b1, 8'd9},
      // R11: all-zero word, register-register encoding aimed at index 0
      '{32'h00000000, 32'd0, 32'd0, 32'd0, 5'd0, 7'h31, 6'd0, 1'b0, 1'b0, 8'd11}
   };

   logic        clk;
   logic        rst_n;
   logic [31:0] instr;
   logic [31:0] rs_v;
   logic [31:0] rt_v;
   logic [31:0] instr_o;
   logic [6:0]  ctrl_o;
   logic [5:0]  aluop_o;
   logic [31:0] result_o;
   logic [4:0]  dest_o;
   logic        wr_en_o;
   logic        unsup_o;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   dx_unit uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .instr_i  (instr),
      .rs_val_i (rs_v),
      .rt_val_i (rt_v),
      .instr_o  (instr_o),
      .ctrl_o   (ctrl_o),
      .aluop_o  (aluop_o),
      .result_o (result_o),
      .dest_o   (dest_o),
      .wr_en_o  (wr_en_o),
      .unsup_o  (unsup_o)
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string what, input int req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_idle(input int req);
      chk("instr_o",  req, instr_o,  32'd0);
      chk("ctrl_o",   req, 32'(ctrl_o),   32'd0);
      chk("aluop_o",  req, 32'(aluop_o),  32'd0);
      chk("result_o", req, result_o, 32'd0);
      chk("dest_o",   req, 32'(dest_o),   32'd0);
      chk("wr_en_o",  req, 32'(wr_en_o),  32'd0);
      chk("unsup_o",  req, 32'(unsup_o),  32'd0);
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      instr = 32'h0;
      rs_v  = 32'h0;
      rt_v  = 32'h0;
      repeat (3) @(posedge clk);
      #1;
      chk_idle(1); // R1: state held in reset
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         instr = VEC[i].instr;
         rs_v  = VEC[i].rs;
         rt_v  = VEC[i].rt;
         @(posedge clk);
         #1;
         chk("result_o", VEC[i].req, result_o,            VEC[i].res);
         chk("dest_o",   VEC[i].req, 32'(dest_o),         32'(VEC[i].dest));
         chk("ctrl_o",   VEC[i].req, 32'(ctrl_o),         32'(VEC[i].ctrl));
         chk("aluop_o",  VEC[i].req, 32'(aluop_o),        32'(VEC[i].op));
         chk("wr_en_o",  VEC[i].req, 32'(wr_en_o),        32'(VEC[i].we));
         chk("unsup_o",  VEC[i].req, 32'(unsup_o),        32'(VEC[i].unsup));
         chk("instr_o",  VEC[i].req, instr_o,             VEC[i].instr);
      end

      // R2: new inputs between edges leave outputs alone, then appear after one edge
      instr = enc_r(1, 2, 3, 0, 33);
      rs_v  = 32'd100;
      rt_v  = 32'd23;
      #2;
      chk("result_o before edge", 2, result_o, 32'd0);
      chk("ctrl_o before edge",   2, 32'(ctrl_o), 32'h31);
      chk("dest_o before edge",   2, 32'(dest_o), 32'd0);
      @(posedge clk);
      #1;
      chk("result_o after edge",  2, result_o, 32'd123);
      chk("wr_en_o after edge",   2, 32'(wr_en_o), 32'd1);

      // R1: reset in mid-stream clears the stage at once
      instr = enc_i(8, 1, 9, 16'h0001);
      rs_v  = 32'd41;
      rst_n = 1'b0;
      #1;
      chk_idle(1);
      @(posedge clk);
      #1;
      chk_idle(1);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("result_o after reset release", 5, result_o, 32'd42); // R5
      chk("dest_o after reset release",   5, 32'(dest_o), 32'd9);

      // R10: index-0 destination via register-register form
      instr = enc_r(1, 2, 0, 0, 37);
      rs_v  = 32'h1;
      rt_v  = 32'h2;
      @(posedge clk);
      #1;
      chk("wr_en_o rd=0",  10, 32'(wr_en_o), 32'd0);
      chk("ctrl_o rd=0",   10, 32'(ctrl_o), 32'h31);
      chk("result_o rd=0", 10, result_o, 32'd3);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule